// File: doc/BRIEF.md
# Two-Channel Interval Timer

This block is a small programmable interval timer with two counters, called counter 0 and counter 2. Both are programmed through one byte-wide write port. The tick input is a one-cycle enable pulse. In a system it is pulsed at the standard timer input rate of 1,193,180 Hz, and every counter advances only on those pulses.

A control word chooses a counter and sets its operating mode. The 16-bit count is then written as two bytes to that counter's data port, low byte first. The counter starts only when the high byte arrives. In one-shot mode the counter stops at terminal count and raises a flag in its status byte. In every other mode it reloads and runs again.

Both counters share one flag that remembers a pending low byte. The high byte therefore programs whichever counter it is written to. Control words that this block does not support produce a one-cycle error pulse and change nothing.

Top module: `pit_lite`

## Requirements
- R1: After reset, both status bytes read 0x00, the error output is low, no counter runs and no low byte is pending.
- R2: A control write (wr_port = 2) whose bits 5:4 are not 2'b11 makes cmd_err high for exactly the following cycle and changes no counter's mode.
- R3: In a control write with bits 5:4 = 2'b11, bits 7:6 = 0 selects counter 0 and bits 7:6 = 2 selects counter 2. Values 1 and 3 raise cmd_err for the following cycle and change nothing.
- R4: An accepted control word stores bits 3:1 as the selected counter's mode. Mode 0 is one-shot and every other mode repeats.
- R5: A counter's data port is wr_port 0 for counter 0 and wr_port 1 for counter 2. When no low byte is pending, a data write only stores the low byte. When a low byte is pending, the write loads {data, low} into the target counter, starts it and clears its status byte to 0x00.
- R6: The pending-low flag is shared by both data ports. A low byte written to counter 0's port followed by a high byte written to counter 2's port programs counter 2 and leaves counter 0 untouched.
- R7: In mode 0, a counter loaded with N shows status 0x20 after its N-th tick following the load, and then stops.
- R8: In a repeating mode, a counter reloads at each expiry and its status stays 0x00. A mode written while the counter runs takes effect at the next expiry.
- R9: A loaded count of 0 runs for 65536 ticks.
- R10: A counter does not change on cycles where tick is low.
- R11: rd_status is counter 2's status byte and c0_status is counter 0's status byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable pulse |
| wr_en | input | 1 | Write strobe |
| wr_port | input | 2 | 0: counter 0 data, 1: counter 2 data, 2: control, 3: ignored |
| wr_data | input | 8 | Write byte |
| rd_status | output | 8 | Counter 2 status byte (0x20 when expired) |
| c0_status | output | 8 | Counter 0 status byte |
| cmd_err | output | 1 | One-cycle pulse after an unsupported control word |

## Verification
On every cycle, the assertions check four things. Malformed and bad-select control words must produce the error pulse, and the error pulse must have a control write as its cause. The status byte may only take its two legal values. An expired status must hold until a high-byte write to counter 2.

Only the bench's scenarios can show the rest: that the counts decrement only on tick pulses, the exact cycle of expiry, the shared low-byte pairing across ports, reload in repeat mode, a mode change taking effect at the next expiry, and the full 65536-tick run for a zero count. The bench covers these with a behavioural model compared on every clock, plus directed checks.

// File: rtl/pit_lite.sv
module pit_lite #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [1:0]        wr_port,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] rd_status,
  output logic [BYTE_W-1:0] c0_status,
  output logic              cmd_err
);
  localparam int           CNT_W   = 2 * BYTE_W;
  localparam logic [1:0]   P_D0    = 2'd0;
  localparam logic [1:0]   P_D2    = 2'd1;
  localparam logic [1:0]   P_CTL   = 2'd2;
  localparam logic [BYTE_W-1:0] ST_DONE = BYTE_W'(8'h20);
  localparam logic [CNT_W:0] FULL  = (CNT_W+1)'(1) << CNT_W;
  localparam logic [CNT_W:0] ONE   = (CNT_W+1)'(1);

  logic              pend_q;
  logic [BYTE_W-1:0] lo_q;
  logic [BYTE_W-1:0] stat [2];

  wire ctl_wr  = wr_en && (wr_port == P_CTL);
  wire fmt_ok  = (wr_data[5:4] == 2'b11);
  wire sel_ok  = (wr_data[7:6] == 2'd0) || (wr_data[7:6] == 2'd2);
  wire data_wr = wr_en && ((wr_port == P_D0) || (wr_port == P_D2));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_err <= 1'b0;
      pend_q  <= 1'b0;
      lo_q    <= '0;
    end else begin
      cmd_err <= ctl_wr && !(fmt_ok && sel_ok);
      if (data_wr) begin
        pend_q <= !pend_q;
        if (!pend_q) lo_q <= wr_data;
      end
    end
  end

  for (genvar i = 0; i < 2; i++) begin : g_ctr
    localparam logic [1:0] DPORT = (i == 0) ? P_D0 : P_D2;
    localparam logic [1:0] SEL   = (i == 0) ? 2'd0 : 2'd2;

    logic [2:0]        mode_q;
    logic              run_q;
    logic [CNT_W-1:0]  rel_q;
    logic [CNT_W:0]    cnt_q;
    logic [BYTE_W-1:0] st_q;

    wire              load    = wr_en && (wr_port == DPORT) && pend_q;
    wire              mode_wr = ctl_wr && fmt_ok && (wr_data[7:6] == SEL);
    wire [CNT_W-1:0]  new_val = {wr_data, lo_q};
    wire [CNT_W:0]    new_cnt = (new_val == '0) ? FULL : {1'b0, new_val};
    wire [CNT_W:0]    rel_cnt = (rel_q == '0) ? FULL : {1'b0, rel_q};

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mode_q <= '0;
        run_q  <= 1'b0;
        rel_q  <= '0;
        cnt_q  <= '0;
        st_q   <= '0;
      end else begin
        if (mode_wr) mode_q <= wr_data[3:1];
        if (load) begin
          rel_q <= new_val;
          cnt_q <= new_cnt;
          run_q <= 1'b1;
          st_q  <= '0;
        end else if (run_q && tick) begin
          if (cnt_q == ONE) begin
            if (mode_q == 3'd0) begin
              run_q <= 1'b0;
              st_q  <= ST_DONE;
              cnt_q <= '0;
            end else begin
              cnt_q <= rel_cnt;
            end
          end else begin
            cnt_q <= cnt_q - ONE;
          end
        end
      end
    end

    assign stat[i] = st_q;
  end

  assign rd_status = stat[1];
  assign c0_status = stat[0];
endmodule

module pit_lite_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [1:0] wr_port,
  input logic [7:0] wr_data,
  input logic [7:0] rd_status,
  input logic       cmd_err
);
  a_r2_bad_format: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_port == 2'd2 && wr_data[5:4] != 2'b11) |=> cmd_err);

  a_r3_bad_select: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_port == 2'd2 && wr_data[5:4] == 2'b11 && wr_data[6]) |=> cmd_err);

  a_r3_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> $past(wr_en && wr_port == 2'd2));

  a_r7_status_codes: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_status == 8'h00) || (rd_status == 8'h20));

  a_r7_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_status == 8'h20 && !(wr_en && wr_port == 2'd1)) |=> (rd_status == 8'h20));
endmodule

bind pit_lite pit_lite_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_port(wr_port),
  .wr_data(wr_data), .rd_status(rd_status), .cmd_err(cmd_err)
);

// File: tb/pit_lite_tb.sv
`timescale 1ns/1ps
module pit_lite_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_port = 2'd3;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_status, c0_status;
  logic       cmd_err;

  int total = 0;
  int bad = 0;
  bit done = 0;

  pit_lite u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_port(wr_port),
    .wr_data(wr_data), .rd_status(rd_status), .c0_status(c0_status), .cmd_err(cmd_err)
  );

  always #10 clk = ~clk;

  // behavioural reference model
  int m_cnt [2], m_rel [2], m_mode [2], m_st [2];
  bit m_run [2];
  bit m_pend, m_err;
  int m_lo;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 2; k++) begin
        m_cnt[k] = 0; m_rel[k] = 0; m_mode[k] = 0; m_st[k] = 0; m_run[k] = 0;
      end
      m_pend = 0; m_err = 0; m_lo = 0;
    end else begin
      int  nmode [2];
      bit  ctl, good;
      int  sel, tgt;
      nmode[0] = m_mode[0]; nmode[1] = m_mode[1];
      ctl  = wr_en && wr_port == 2;
      sel  = wr_data[7:6];
      good = (wr_data[5:4] == 3) && (sel == 0 || sel == 2);
      m_err = ctl && !good;
      if (ctl && good) nmode[sel / 2] = wr_data[3:1];
      tgt = -1;
      if (wr_en && wr_port < 2) begin
        if (m_pend) tgt = wr_port;
        else m_lo = wr_data;
        m_pend = !m_pend;
      end
      for (int k = 0; k < 2; k++) begin
        if (tgt == k) begin
          m_rel[k] = wr_data * 256 + m_lo;
          m_cnt[k] = (m_rel[k] == 0) ? 65536 : m_rel[k];
          m_run[k] = 1; m_st[k] = 0;
        end else if (m_run[k] && tick) begin
          if (m_cnt[k] == 1) begin
            if (m_mode[k] == 0) begin m_run[k] = 0; m_st[k] = 32; end
            else m_cnt[k] = (m_rel[k] == 0) ? 65536 : m_rel[k];
          end else m_cnt[k] = m_cnt[k] - 1;
        end
      end
      m_mode[0] = nmode[0]; m_mode[1] = nmode[1];
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R11 counter2 status vs model", rd_status, m_st[1]);
      chk("R11 counter0 status vs model", c0_status, m_st[0]);
      chk("R2 error pulse vs model", cmd_err, m_err);
    end
  end

  task automatic wr(input logic [1:0] p, input logic [7:0] d);
    wr_en = 1'b1; wr_port = p; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_port = 2'd3;
  endtask

  initial begin
    #(20.0 * 200000);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset rd_status", rd_status, 0);
    chk("R1 reset c0_status", c0_status, 0);
    chk("R1 reset cmd_err", cmd_err, 0);

    // control word errors
    wr(2, 8'h00); chk("R2 bad format err", cmd_err, 1);
    @(negedge clk); chk("R2 err one cycle", cmd_err, 0);
    wr(2, 8'h70); chk("R3 select 1 err", cmd_err, 1);
    wr(2, 8'hF0); chk("R3 select 3 err", cmd_err, 1);
    wr(2, 8'hB0); chk("R3 select 2 accepted", cmd_err, 0);

    // one-shot counter 2, count 5
    wr(1, 8'h05);
    wr(1, 8'h00);
    tick = 1'b1;
    repeat (4) @(negedge clk);
    chk("R7 not yet expired", rd_status, 0);
    @(negedge clk);
    chk("R7 expiry after N ticks", rd_status, 8'h20);
    repeat (3) @(negedge clk);
    chk("R7 stays stopped", rd_status, 8'h20);
    tick = 1'b0;

    // tick gating on counter 0, count 3
    wr(2, 8'h30);
    wr(0, 8'h03);
    wr(0, 8'h00);
    repeat (5) @(negedge clk);
    tick = 1'b1; repeat (2) @(negedge clk);
    tick = 1'b0; repeat (4) @(negedge clk);
    chk("R10 idle cycles do not count", c0_status, 0);
    tick = 1'b1; @(negedge clk); tick = 1'b0;
    chk("R10 third tick expires", c0_status, 8'h20);

    // shared pending flag
    wr(0, 8'h07);
    chk("R5 low byte alone does not start", rd_status, 8'h20);
    chk("R6 counter0 untouched by low byte", c0_status, 8'h20);
    wr(1, 8'h00);
    chk("R5 start clears status", rd_status, 0);
    chk("R6 counter0 untouched by cross pair", c0_status, 8'h20);
    tick = 1'b1;
    repeat (6) @(negedge clk);
    chk("R6 cross-paired count pending", rd_status, 0);
    @(negedge clk);
    chk("R6 cross-paired count 7 expired", rd_status, 8'h20);
    tick = 1'b0;

    // repeating mode on counter 2, count 4
    wr(2, 8'hB4);
    wr(1, 8'h04);
    wr(1, 8'h00);
    tick = 1'b1;
    repeat (5) @(negedge clk);
    wr(2, 8'h80);
    chk("R2 malformed word flagged", cmd_err, 1);
    repeat (4) @(negedge clk);
    chk("R4 R8 repeat mode keeps status clear", rd_status, 0);
    wr(2, 8'hB0);
    chk("R8 mode change waits for expiry", rd_status, 0);
    @(negedge clk);
    chk("R8 one-shot at next expiry", rd_status, 8'h20);
    tick = 1'b0;

    // zero count on counter 0
    wr(2, 8'h30);
    wr(0, 8'h00);
    wr(0, 8'h00);
    chk("R9 zero load clears status", c0_status, 0);
    tick = 1'b1;
    repeat (65535) @(negedge clk);
    chk("R9 not expired at 65535", c0_status, 0);
    @(negedge clk);
    chk("R9 expired at 65536", c0_status, 8'h20);
    tick = 1'b0;
    repeat (3) @(negedge clk);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule